// File: doc/BRIEF.md
# External Bus Transfer Sequencer

This block runs single read and write transfers on an external, acknowledge-terminated memory bus. An internal requester presents an address, a direction, a 2-bit size code and write data. The block then drives the external address, direction line, start and in-progress strobes, size code, chip select, byte-lane selects, output enable and the write data driver enable. It waits for the slave's acknowledge, and finally returns the captured read data with a one-cycle done pulse.

The block runs on an internal clock at twice the bus clock rate and generates the bus clock itself. Every internal cycle is one half of a bus clock period. A transfer is built from half-period states S0 to S5. Even states fall in the high phase of the bus clock and odd states in the low phase. If the slave acknowledges during S1, the transfer is fast-terminated and skips S2 and S3. Otherwise S2/S3 pairs repeat as whole-cycle wait states until the acknowledge is sampled. All strobes are active high.

Top module: `ebus_master`

## Requirements
- R1: While reset is held, `bclk_o`, `ts_o`, `tip_o`, `cs_o`, `oe_o`, `dq_oe_o` and `done_o` are 0, `bs_o` is 0 and `rw_o` is 1.
- R2: `bclk_o` toggles on every internal clock edge, and every even state (S0, S2, S4) lies in its high phase.
- R3: A request is taken only while idle, and S0 always starts at a rising edge of `bclk_o`. From S0 onward `addr_o`, `siz_o` and `rw_o` (1 = read, 0 = write) show the request, and `ts_o` and `tip_o` are asserted.
- R4: `cs_o`, the byte selects and, for reads only, `oe_o` assert one internal cycle after `ts_o`, at the falling edge of `bclk_o` that begins S1.
- R5: `ts_o` lasts exactly two internal cycles, which is one bus clock period.
- R6: If `ta_i` is 1 at the rising edge that ends S1, the transfer goes straight to S4. The whole transfer then lasts 4 internal cycles.
- R7: Otherwise `ta_i` is sampled only at the rising edges that end S3, and each unacknowledged bus cycle adds 2 internal cycles. `ta_i` seen during an even state is ignored.
- R8: For writes, `dq_oe_o` is 1 from the first state after S1 (S2, or S4 on the fast path) through the end of S5. It is never 1 for reads.
- R9: `dq_i` is captured at the edge where the acknowledge is sampled. Later changes of `dq_i` do not alter `rdata_o`.
- R10: `cs_o`, `bs_o`, `oe_o` and `tip_o` all negate at the start of S5.
- R11: `bs_o[i]` selects byte lane i (`dq[8i+7:8i]`). For size 01 (byte), only lane `addr[1:0]` is selected. For size 10 (word), lanes 1:0 are selected when `addr[1]`=0 and lanes 3:2 otherwise. For size 00 (long) and 11, all four lanes are selected.
- R12: `done_o` is a one-cycle pulse in the internal cycle after S5, with `rdata_o` valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock, twice the bus clock rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Transfer request, held until `ts_o` is seen |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Transfer address |
| req_size_i | input | 2 | Size code (00 long, 01 byte, 10 word, 11 long) |
| req_wdata_i | input | DATA_W | Write data |
| done_o | output | 1 | One-cycle transfer completion pulse |
| rdata_o | output | DATA_W | Captured read data |
| bclk_o | output | 1 | Generated bus clock |
| addr_o | output | ADDR_W | External address |
| rw_o | output | 1 | Direction, 1 = read |
| ts_o | output | 1 | Transfer start strobe |
| tip_o | output | 1 | Transfer in progress |
| siz_o | output | 2 | Size code |
| cs_o | output | 1 | Chip select |
| bs_o | output | DATA_W/8 | Byte-lane selects |
| oe_o | output | 1 | Output enable for reads |
| ta_i | input | 1 | Transfer acknowledge from the slave |
| dq_i | input | DATA_W | Data bus input |
| dq_o | output | DATA_W | Data bus output |
| dq_oe_o | output | 1 | Data bus driver enable |

## Verification
The bench counts internal cycles from the first falling edge of `clk_i` at which `ts_o` reads 1. That cycle is n=0 (S0). Each output is then due in a cycle given by that index. `cs_o`, `bs_o` and `oe_o` are due at n=1, and `ts_o` drops at n=2. With w wait states the transfer length is L=4+2w: `tip_o` and `cs_o` drop at n=L-1, and `done_o` with `rdata_o` appears at n=L and is gone at n=L+1. The acknowledge is driven at falling edges so that it is sampled at the rising edge ending cycle n=1+2w. All outputs are sampled at falling edges, half a period away from the edge that updates them.

// File: rtl/ebus_pkg.sv
package ebus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_S0, ST_S1, ST_S2, ST_S3, ST_S4, ST_S5
  } bus_st_e;

  localparam logic [1:0] SZ_LONG = 2'b00;
  localparam logic [1:0] SZ_BYTE = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;
  localparam logic [1:0] SZ_LINE = 2'b11;
endpackage

// File: rtl/ebus_lane_dec.sv
module ebus_lane_dec
  import ebus_pkg::*;
#(
  parameter int LANES = 4,
  parameter int LB    = $clog2(LANES)
) (
  input  logic [1:0]       size_i,
  input  logic [LB-1:0]    off_i,
  output logic [LANES-1:0] mask_o
);
  int span;
  int base;

  always_comb begin
    case (size_i)
      SZ_BYTE: span = 1;
      SZ_WORD: span = 2;
      default: span = LANES;
    endcase
    base = int'(off_i) & ~(span - 1);
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign mask_o[i] = (i >= base) && (i < base + span);
  end

  always_comb begin
    if (size_i == SZ_BYTE) begin
      assert_byte_one_lane_R11: assert ($onehot(mask_o));
    end
  end
endmodule

// File: rtl/ebus_seq.sv
module ebus_seq
  import ebus_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    req_i,
  input  logic    ta_i,
  output bus_st_e st_o,
  output logic    bclk_o,
  output logic    start_o,
  output logic    cap_o,
  output logic    done_o
);
  bus_st_e st_q, st_d;
  logic    hi_q;
  logic    done_q;

  // S0 must land in the high phase, so accept only while the clock is low
  assign start_o = (st_q == ST_IDLE) && req_i && !hi_q;
  assign cap_o   = ((st_q == ST_S1) || (st_q == ST_S3)) && ta_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start_o) st_d = ST_S0;
      ST_S0:   st_d = ST_S1;
      ST_S1:   st_d = ta_i ? ST_S4 : ST_S2;
      ST_S2:   st_d = ST_S3;
      ST_S3:   st_d = ta_i ? ST_S4 : ST_S2;
      ST_S4:   st_d = ST_S5;
      ST_S5:   st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      hi_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      hi_q   <= !hi_q;
      done_q <= (st_q == ST_S5);
    end
  end

  assign st_o   = st_q;
  assign bclk_o = hi_q;
  assign done_o = done_q;

  assert_even_high_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q inside {ST_S0, ST_S2, ST_S4}) |-> hi_q);

  assert_fast_path_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_S1 && ta_i) |=> (st_q == ST_S4));

  assert_done_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
endmodule

// File: rtl/ebus_master.sv
module ebus_master
  import ebus_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                req_we_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic [1:0]          req_size_i,
  input  logic [DATA_W-1:0]   req_wdata_i,
  output logic                done_o,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                bclk_o,
  output logic [ADDR_W-1:0]   addr_o,
  output logic                rw_o,
  output logic                ts_o,
  output logic                tip_o,
  output logic [1:0]          siz_o,
  output logic                cs_o,
  output logic [DATA_W/8-1:0] bs_o,
  output logic                oe_o,
  input  logic                ta_i,
  input  logic [DATA_W-1:0]   dq_i,
  output logic [DATA_W-1:0]   dq_o,
  output logic                dq_oe_o
);
  localparam int LANES = DATA_W / 8;
  localparam int LB    = $clog2(LANES);

  bus_st_e           st;
  logic              start, cap;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q;
  logic [1:0]        size_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic [LANES-1:0]  lane_mask;

  ebus_seq u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .ta_i    (ta_i),
    .st_o    (st),
    .bclk_o  (bclk_o),
    .start_o (start),
    .cap_o   (cap),
    .done_o  (done_o)
  );

  ebus_lane_dec #(.LANES(LANES), .LB(LB)) u_lane (
    .size_i (size_q),
    .off_i  (addr_q[LB-1:0]),
    .mask_o (lane_mask)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      we_q    <= 1'b0;
      size_q  <= SZ_LONG;
      wdata_q <= '0;
    end else if (start) begin
      addr_q  <= req_addr_i;
      we_q    <= req_we_i;
      size_q  <= req_size_i;
      wdata_q <= req_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (cap) rdata_q <= dq_i;
  end

  assign ts_o    = st inside {ST_S0, ST_S1};
  assign tip_o   = (st != ST_IDLE) && (st != ST_S5);
  assign cs_o    = st inside {ST_S1, ST_S2, ST_S3, ST_S4};
  assign bs_o    = cs_o ? lane_mask : '0;
  assign oe_o    = cs_o && !we_q;
  assign rw_o    = (st == ST_IDLE) || !we_q;
  assign addr_o  = addr_q;
  assign siz_o   = size_q;
  // driver stays on through S5 so the slave sees stable data to the end
  assign dq_oe_o = we_q && (st inside {ST_S2, ST_S3, ST_S4, ST_S5});
  assign dq_o    = wdata_q;
  assign rdata_o = rdata_q;

  assert_ts_in_tip_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ts_o |-> tip_o);

  assert_ts_high_phase_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ts_o) |-> bclk_o);

  assert_cs_after_ts_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_o) |-> (!bclk_o && $past(ts_o)));

  assert_ts_one_period_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ts_o) |=> ts_o ##1 !ts_o);

  assert_drv_write_only_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> !rw_o);

  assert_cs_tip_fall_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_o) |-> $fell(tip_o));
endmodule

// File: tb/ebus_master_tb.sv
`timescale 1ns/1ps
module ebus_master_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        req_we_i = 1'b0;
  logic [31:0] req_addr_i = '0;
  logic [1:0]  req_size_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic        ta_i = 1'b0;
  logic [31:0] dq_i = '0;
  logic        done_o, bclk_o, rw_o, ts_o, tip_o, cs_o, oe_o, dq_oe_o;
  logic [31:0] rdata_o, addr_o, dq_o;
  logic [1:0]  siz_o;
  logic [3:0]  bs_o;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk_i = !clk_i;

  ebus_master u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .req_we_i(req_we_i),
    .req_addr_i(req_addr_i), .req_size_i(req_size_i), .req_wdata_i(req_wdata_i),
    .done_o(done_o), .rdata_o(rdata_o), .bclk_o(bclk_o), .addr_o(addr_o),
    .rw_o(rw_o), .ts_o(ts_o), .tip_o(tip_o), .siz_o(siz_o), .cs_o(cs_o),
    .bs_o(bs_o), .oe_o(oe_o), .ta_i(ta_i), .dq_i(dq_i), .dq_o(dq_o),
    .dq_oe_o(dq_oe_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  function automatic logic [3:0] exp_bs(input logic [1:0] sz, input logic [31:0] a);
    case (sz)
      2'b01:   return 4'b0001 << a[1:0];
      2'b10:   return a[1] ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  // one transfer with w wait states, checked cycle by cycle from S0
  task automatic xfer(input bit we, input logic [31:0] a, input logic [1:0] sz,
                      input logic [31:0] wd, input int w, input logic [31:0] rd);
    int L = 4 + 2 * w;
    int guard = 0;
    string tk = (w == 0) ? "R6" : "R7";
    @(negedge clk_i);
    req_we_i = we; req_addr_i = a; req_size_i = sz; req_wdata_i = wd; req_i = 1'b1;
    do begin @(negedge clk_i); guard++; end while (!ts_o && guard < 8);
    chk(ts_o, "R3 request accepted", 32'(ts_o), 1);
    req_i = 1'b0;
    for (int n = 0; n <= L + 1; n++) begin
      bit cs_e = (n >= 1) && (n < L - 1);
      chk(bclk_o == (n % 2 == 0), "R2 bclk_o phase", 32'(bclk_o), 32'(n % 2 == 0));
      chk(ts_o == (n < 2), "R5 ts_o", 32'(ts_o), 32'(n < 2));
      chk(tip_o == (n < L - 1), {tk, " tip_o length"}, 32'(tip_o), 32'(n < L - 1));
      chk(cs_o == cs_e, (n == L - 1) ? "R10 cs_o at S5" : "R4 cs_o", 32'(cs_o), 32'(cs_e));
      chk(bs_o == (cs_e ? exp_bs(sz, a) : 4'b0), "R11 bs_o", 32'(bs_o),
          32'(cs_e ? exp_bs(sz, a) : 4'b0));
      chk(oe_o == (cs_e && !we), "R4 oe_o", 32'(oe_o), 32'(cs_e && !we));
      chk(dq_oe_o == (we && n >= 2 && n <= L - 1), "R8 dq_oe_o", 32'(dq_oe_o),
          32'(we && n >= 2 && n <= L - 1));
      if (we && n >= 2 && n <= L - 1) chk(dq_o == wd, "R8 dq_o", dq_o, wd);
      if (n < L) begin
        chk(addr_o == a, "R3 addr_o", addr_o, a);
        chk(siz_o == sz, "R3 siz_o", 32'(siz_o), 32'(sz));
        chk(rw_o == !we, "R3 rw_o", 32'(rw_o), 32'(!we));
      end
      chk(done_o == (n == L), "R12 done_o", 32'(done_o), 32'(n == L));
      if (!we && n >= L) chk(rdata_o == rd, "R9 rdata_o", rdata_o, rd);
      // drive slave response for the edge that ends this cycle
      ta_i = (n == 1 + 2 * w) || (w >= 1 && n == 2);
      if (n == 1 + 2 * w) dq_i = rd;
      else if (n >= L - 1) dq_i = ~rd;
      else dq_i = 32'h5A5A_0F0F;
      @(negedge clk_i);
    end
    ta_i = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk_i);
    chk(bclk_o == 0 && ts_o == 0 && tip_o == 0, "R1 clock and strobes",
        {29'b0, bclk_o, ts_o, tip_o}, 0);
    chk(cs_o == 0 && oe_o == 0 && dq_oe_o == 0 && done_o == 0, "R1 selects",
        {28'b0, cs_o, oe_o, dq_oe_o, done_o}, 0);
    chk(bs_o == 0, "R1 bs_o", 32'(bs_o), 0);
    chk(rw_o == 1, "R1 rw_o", 32'(rw_o), 1);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(tip_o == 0, "R3 idle without request", 32'(tip_o), 0);
  endtask

  task automatic t_fast_read();
    xfer(1'b0, 32'h1000_0040, 2'b00, 32'h0, 0, 32'hCAFE_1234);
  endtask

  task automatic t_wait_read();
    xfer(1'b0, 32'h2000_0003, 2'b01, 32'h0, 2, 32'h1122_3344);
  endtask

  task automatic t_fast_write();
    xfer(1'b1, 32'h3000_0002, 2'b10, 32'hA5A5_5A5A, 0, 32'h0);
  endtask

  task automatic t_wait_write();
    xfer(1'b1, 32'h3000_0101, 2'b01, 32'h0BAD_F00D, 3, 32'h0);
  endtask

  task automatic t_lanes();
    for (int i = 0; i < 4; i++)
      xfer(1'b0, 32'h4000_0000 + 32'(i), 2'b01, 32'h0, 0, 32'h0100_0000 * (i + 1));
    xfer(1'b0, 32'h4000_0000, 2'b10, 32'h0, 1, 32'h7777_8888);
    xfer(1'b0, 32'h4000_0006, 2'b11, 32'h0, 0, 32'h9999_AAAA);
  endtask

  initial begin
    t_reset();
    t_fast_read();
    t_wait_read();
    t_fast_write();
    t_wait_write();
    t_lanes();
    repeat (4) @(negedge clk_i);
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end
endmodule